// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block feeds the feedback divider of a fractional-N frequency synthesizer. Once per phase-comparison cycle, marked by a one-clock step strobe, it produces the integer divide ratio the divider must use for that cycle. Over many cycles the mean of these ratios equals the programmed integer part plus a 15-bit fraction. The fraction is built from a 12-bit fine-tuning value and a signed trim word that corrects the reference frequency.

A three-stage cascade of first-order accumulators forms a third-order noise-shaping modulator. It turns the fraction into a small signed offset for each cycle, and the offset is added to the integer base. When the trim pushes the fraction below zero or past its full scale, the overflow is carried into the integer base, so the programmed ratio has no break. Each instantaneous ratio is split into the two loads of a pulse-swallow divider that uses a dual-modulus prescaler of 4/5 or 8/9. A flag is raised when the ratio falls outside the range that divider can produce.

Top module: `fracn_ratio_seq`

## Requirements
- R1: While reset is asserted at a clock edge, the ratio, both counter loads and the range flag become zero and the three accumulators and the delayed carries are cleared.
- R2: Outputs and modulator state change only at a clock edge where step_i is 1. With step_i at 0, input changes have no effect on any output.
- R3: The fractional word is W = 8 * nfr_i + cor_i, where cor_i is 11-bit two's complement. On the first step after reset the offset is 0, so ratio_o equals the integer base.
- R4: If W < 0, the base is int_i - 1 and the fraction is W + 32768. If W >= 32768, the base is int_i + 1 and the fraction is W - 32768. Otherwise the base is int_i and the fraction is W.
- R5: On every step, ratio_o minus the integer base lies in the range -3 to +4.
- R6: The sum of ratio_o over the first 32768 steps after reset, with the inputs held constant, differs from int_i * 32768 + W by at most 2.
- R7: Changing the inputs does not clear the accumulators. Starting from reset with nfr_i = 2048 and cor_i = 0 for one step, then nfr_i = 0, the ratios on the first three steps are int_i, int_i + 1 and int_i.
- R8: The prescaler modulus P is 4 when psel_i = 0 and 8 when psel_i = 1. For a legal ratio N, bcnt_o = N div P and acnt_o = N mod P, with bcnt_o >= acnt_o.
- R9: A ratio is legal when P*P + 3P + 3 <= N <= 255, which gives lower bounds of 31 and 91. For any other N, range_err_o is 1 and the loads are taken from N clamped to the nearer bound. Negative N are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | One pulse per phase-comparison cycle; gates all updates |
| int_i | input | 8 | Integer part of the divide ratio |
| nfr_i | input | 12 | Fine fractional value (scaled by 8 into the 15-bit word) |
| cor_i | input | 11 | Two's-complement reference trim added to the fractional word |
| psel_i | input | 1 | Prescaler select: 0 = 4/5, 1 = 8/9 |
| ratio_o | output | 10 | Instantaneous divide ratio, two's complement |
| bcnt_o | output | 8 | Main counter load (N div P) |
| acnt_o | output | 3 | Swallow counter load (N mod P) |
| range_err_o | output | 1 | Ratio outside the legal range for the selected prescaler |

## Verification
The bench builds the block with its default parameters: an 8-bit integer part, a 12-bit fine value, an 11-bit trim, a 15-bit fraction and prescaler moduli 4 and 8. With these values, a full accumulator period of 32768 steps fits in three long runs, so the mean ratio can be checked against the programmed value. The real range limits of 31, 91 and 255 can be reached directly. Ratios that wrap below zero or past full scale are driven, and so are the clamped loads that belong to them. In every run, each ratio is checked against its per-step offset window, its counter split and its range flag.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the fractional-N ratio sequencer.
// Assumes: prescaler moduli are small positive integers.
package fracn_pkg;
    // Modulator order (number of cascaded accumulators).
    localparam int ORDER = 3;
    // Width of the signed per-step offset (range -3..+4).
    localparam int OFF_W = 4;

    // Smallest ratio a pulse-swallow divider reaches with modulus p.
    function automatic int nmin_f(input int p);
        return p * p + 3 * p + 3;
    endfunction
endpackage

// File: rtl/fracn_word_fmt.sv
`timescale 1ns/1ps
// Forms the 15-bit fraction from the fine value and the signed trim,
// folding any wrap below zero or past full scale into the integer base.
// Assumes: COR_W <= FR_W + 2 and NFR_W <= FR_W.
module fracn_word_fmt #(
    parameter int INT_W = 8,
    parameter int NFR_W = 12,
    parameter int COR_W = 11,
    parameter int FR_W  = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INT_W-1:0]          int_i,
    input  logic [NFR_W-1:0]          nfr_i,
    input  logic [COR_W-1:0]          cor_i,
    output logic signed [INT_W+1:0]   base_o,
    output logic [FR_W-1:0]           frac_o
);
    localparam int SHIFT  = FR_W - NFR_W;
    localparam int SUM_W  = FR_W + 2;
    localparam int BASE_W = INT_W + 2;

    logic signed [SUM_W-1:0]  word_s;
    logic signed [BASE_W-1:0] adj_s;

    // Scaled fine value plus sign-extended trim.
    assign word_s = $signed({{(SUM_W-FR_W){1'b0}}, nfr_i, {SHIFT{1'b0}}})
                  + $signed({{(SUM_W-COR_W){cor_i[COR_W-1]}}, cor_i});

    // Select the integer adjustment from the two top bits of the word.
    always_comb begin
        case (word_s[SUM_W-1:SUM_W-2])
            2'b11:   adj_s = -1;
            2'b01:   adj_s = 1;
            default: adj_s = '0;
        endcase
    end

    assign frac_o = word_s[FR_W-1:0];
    assign base_o = $signed({2'b00, int_i}) + adj_s;

    // Rebuild the full ratio from base and fraction for the checker.
    int recon_chk;
    always_comb begin
        recon_chk = (int'(base_o) - int'({2'b00, int_i})) * (1 << FR_W)
                  + int'({1'b0, frac_o});
    end

    // R4
    ratio_continuity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recon_chk == int'(word_s));
endmodule

// File: rtl/fracn_acc_stage.sv
`timescale 1ns/1ps
// One first-order accumulator of the cascade: adds its input to the
// stored value at each enabled edge and reports the wrap carry.
// Assumes: sum_o and carry_o are combinational (the value after the add).
module fracn_acc_stage #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   tot;

    // Modular add with carry out.
    assign tot     = {1'b0, acc_q} + {1'b0, add_i};
    assign sum_o   = tot[W-1:0];
    assign carry_o = tot[W];

    // Store the new residue on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (en_i) acc_q <= sum_o;
    end
endmodule

// File: rtl/fracn_mash3.sv
`timescale 1ns/1ps
// Third-order noise-shaping modulator built from cascaded accumulators
// with digital noise cancellation of the carries.
// Assumes: the input fraction is held between enabled edges.
module fracn_mash3
    import fracn_pkg::*;
#(
    parameter int W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [W-1:0]            x_i,
    output logic signed [OFF_W-1:0] off_o
);
    logic [W-1:0] stg_in  [ORDER];
    logic [W-1:0] stg_sum [ORDER];
    logic         cy      [ORDER];
    logic         c2d, c3d, c3dd;

    assign stg_in[0] = x_i;

    // Cascade: each stage integrates the residue of the one before.
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        if (g > 0) begin : g_link
            assign stg_in[g] = stg_sum[g-1];
        end
        fracn_acc_stage #(.W(W)) acc_u (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .add_i   (stg_in[g]),
            .sum_o   (stg_sum[g]),
            .carry_o (cy[g])
        );
    end

    // Delay the later-stage carries for the differencing network.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2d  <= 1'b0;
            c3d  <= 1'b0;
            c3dd <= 1'b0;
        end else if (en_i) begin
            c2d  <= cy[1];
            c3d  <= cy[2];
            c3dd <= c3d;
        end
    end

    // Combine: c1 + (c2 - c2') + (c3 - 2c3' + c3'').
    always_comb begin
        off_o = $signed({3'b000, cy[0]})
              + $signed({3'b000, cy[1]}) - $signed({3'b000, c2d})
              + $signed({3'b000, cy[2]}) - $signed({2'b00, c3d, 1'b0})
              + $signed({3'b000, c3dd});
    end

    // R5
    offset_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_o >= -4'sd3) && (off_o <= 4'sd4));
endmodule

// File: rtl/fracn_ab_split.sv
`timescale 1ns/1ps
// Splits an instantaneous ratio into main and swallow counter loads for
// a dual-modulus prescaler, clamping and flagging out-of-range ratios.
// Assumes: P_LO < P_HI, both small; NMAX fits in RAT_W-1 bits.
module fracn_ab_split
    import fracn_pkg::*;
#(
    parameter int RAT_W  = 10,
    parameter int BCNT_W = 8,
    parameter int ACNT_W = 3,
    parameter int P_LO   = 4,
    parameter int P_HI   = 8,
    parameter int NMAX   = 255
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [RAT_W-1:0] ratio_i,
    input  logic                    psel_i,
    output logic [BCNT_W-1:0]       bcnt_o,
    output logic [ACNT_W-1:0]       acnt_o,
    output logic                    err_o
);
    localparam int NMIN_LO = nmin_f(P_LO);
    localparam int NMIN_HI = nmin_f(P_HI);

    int r_v, nmin_v, cl_v, p_v;

    // Range test, clamp, then division by the selected constant modulus.
    always_comb begin
        r_v    = int'(ratio_i);
        p_v    = psel_i ? P_HI : P_LO;
        nmin_v = psel_i ? NMIN_HI : NMIN_LO;
        err_o  = (r_v < nmin_v) || (r_v > NMAX);
        if (r_v < nmin_v)    cl_v = nmin_v;
        else if (r_v > NMAX) cl_v = NMAX;
        else                 cl_v = r_v;
        if (psel_i) begin
            bcnt_o = BCNT_W'(cl_v / P_HI);
            acnt_o = ACNT_W'(cl_v % P_HI);
        end else begin
            bcnt_o = BCNT_W'(cl_v / P_LO);
            acnt_o = ACNT_W'(cl_v % P_LO);
        end
    end

    // R8
    ab_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (int'(bcnt_o) * p_v + int'(acnt_o) == int'(ratio_i)));
    // R8
    b_ge_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (bcnt_o >= BCNT_W'(acnt_o)));
endmodule

// File: rtl/fracn_ratio_seq.sv
`timescale 1ns/1ps
// Top of the fractional-N divide ratio sequencer. On every step strobe
// it advances the modulator and registers the new ratio and the loads.
// Assumes: step_i is a single-clock pulse per phase-comparison cycle.
module fracn_ratio_seq
    import fracn_pkg::*;
#(
    parameter int INT_W = 8,
    parameter int NFR_W = 12,
    parameter int COR_W = 11,
    parameter int FR_W  = 15,
    parameter int P_LO  = 4,
    parameter int P_HI  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic [INT_W-1:0]    int_i,
    input  logic [NFR_W-1:0]    nfr_i,
    input  logic [COR_W-1:0]    cor_i,
    input  logic                psel_i,
    output logic [INT_W+1:0]    ratio_o,
    output logic [INT_W-1:0]    bcnt_o,
    output logic [$clog2(P_HI)-1:0] acnt_o,
    output logic                range_err_o
);
    localparam int RAT_W  = INT_W + 2;
    localparam int BCNT_W = INT_W;
    localparam int ACNT_W = $clog2(P_HI);
    localparam int NMAX   = (1 << INT_W) - 1;

    logic signed [RAT_W-1:0] base_s;
    logic [FR_W-1:0]         frac_w;
    logic signed [OFF_W-1:0] off_s;
    logic signed [RAT_W-1:0] ratio_nxt;
    logic [BCNT_W-1:0]       bcnt_nxt;
    logic [ACNT_W-1:0]       acnt_nxt;
    logic                    err_nxt;

    fracn_word_fmt #(
        .INT_W (INT_W), .NFR_W (NFR_W), .COR_W (COR_W), .FR_W (FR_W)
    ) fmt_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .int_i  (int_i),
        .nfr_i  (nfr_i),
        .cor_i  (cor_i),
        .base_o (base_s),
        .frac_o (frac_w)
    );

    fracn_mash3 #(.W(FR_W)) mod_u (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (step_i),
        .x_i   (frac_w),
        .off_o (off_s)
    );

    // Instantaneous ratio: base plus sign-extended offset.
    assign ratio_nxt = base_s + {{(RAT_W-OFF_W){off_s[OFF_W-1]}}, off_s};

    fracn_ab_split #(
        .RAT_W (RAT_W), .BCNT_W (BCNT_W), .ACNT_W (ACNT_W),
        .P_LO (P_LO), .P_HI (P_HI), .NMAX (NMAX)
    ) split_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio_nxt),
        .psel_i  (psel_i),
        .bcnt_o  (bcnt_nxt),
        .acnt_o  (acnt_nxt),
        .err_o   (err_nxt)
    );

    // Register the per-cycle results on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_o     <= '0;
            bcnt_o      <= '0;
            acnt_o      <= '0;
            range_err_o <= 1'b0;
        end else if (step_i) begin
            ratio_o     <= ratio_nxt;
            bcnt_o      <= bcnt_nxt;
            acnt_o      <= acnt_nxt;
            range_err_o <= err_nxt;
        end
    end

    // R2
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable({ratio_o, bcnt_o, acnt_o, range_err_o}));
endmodule

// File: tb/fracn_ratio_seq_tb_top.sv
`timescale 1ns/1ps
module fracn_ratio_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [7:0]  int_i = '0;
    logic [11:0] nfr_i = '0;
    logic [10:0] cor_i = '0;
    logic        psel_i = 1'b0;
    logic [9:0]  ratio_o;
    logic [7:0]  bcnt_o;
    logic [2:0]  acnt_o;
    logic        range_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fracn_ratio_seq dut_i (
        .clk (clk), .rst_n (rst_n), .step_i (step_i), .int_i (int_i),
        .nfr_i (nfr_i), .cor_i (cor_i), .psel_i (psel_i),
        .ratio_o (ratio_o), .bcnt_o (bcnt_o), .acnt_o (acnt_o),
        .range_err_o (range_err_o)
    );

    typedef struct packed {
        logic [7:0]  iv;
        logic [11:0] fv;
        logic [10:0] cv;
        logic        ps;
        logic        lng;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd100, 12'd1234, 11'h000, 1'b0, 1'b1},
        '{8'd120, 12'd0,    11'h7FC, 1'b1, 1'b1},
        '{8'd200, 12'd4095, 11'h3FF, 1'b0, 1'b1},
        '{8'd31,  12'd0,    11'h000, 1'b0, 1'b0},
        '{8'd30,  12'd0,    11'h000, 1'b0, 1'b0},
        '{8'd255, 12'd2048, 11'h000, 1'b1, 1'b0},
        '{8'd91,  12'd3000, 11'h60C, 1'b1, 1'b0},
        '{8'd0,   12'd0,    11'h7FC, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int ratio_val();
        return int'($signed(ratio_o));
    endfunction

    // Offset window, range flag and counter split for the current sample.
    task automatic check_tick(input int base, input bit ps);
        int r, p, nmin, cl;
        bit exp_err;
        r    = ratio_val();
        p    = ps ? 8 : 4;
        nmin = ps ? 91 : 31;
        chk((r - base >= -3) && (r - base <= 4), "R5 offset", r - base, 0);
        exp_err = (r < nmin) || (r > 255);
        chk(range_err_o == exp_err, "R9 flag", int'(range_err_o), int'(exp_err));
        cl = (r < nmin) ? nmin : ((r > 255) ? 255 : r);
        chk(int'(bcnt_o) == cl / p, exp_err ? "R9 bcnt" : "R8 bcnt", int'(bcnt_o), cl / p);
        chk(int'(acnt_o) == cl % p, exp_err ? "R9 acnt" : "R8 acnt", int'(acnt_o), cl % p);
    endtask

    task automatic do_reset();
        step_i = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int w, base, sum, len, r;
        logic [9:0] h_rat;
        logic [7:0] h_b;
        logic [2:0] h_a;
        logic       h_e;

        // R1: reset dominates even with stepping and nonzero inputs
        int_i = 8'd77; nfr_i = 12'd999; cor_i = 11'h123; step_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(ratio_o == '0, "R1 ratio", int'(ratio_o), 0);
        chk(bcnt_o == '0, "R1 bcnt", int'(bcnt_o), 0);
        chk(acnt_o == '0, "R1 acnt", int'(acnt_o), 0);
        chk(range_err_o == 1'b0, "R1 flag", int'(range_err_o), 0);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            int_i  = VECS[v].iv;
            nfr_i  = VECS[v].fv;
            cor_i  = VECS[v].cv;
            psel_i = VECS[v].ps;
            w      = 8 * int'(VECS[v].fv) + int'($signed(VECS[v].cv));
            base   = int'(VECS[v].iv) + ((w < 0) ? -1 : ((w >= 32768) ? 1 : 0));
            len    = VECS[v].lng ? 32768 : 64;
            sum    = 0;
            step_i = 1'b1;
            for (int t = 0; t < len; t++) begin
                @(negedge clk);
                r = ratio_val();
                if (t == 0)
                    chk(r == base, (base == int'(VECS[v].iv)) ? "R3 first" : "R4 first", r, base);
                check_tick(base, VECS[v].ps);
                sum += r;
            end
            step_i = 1'b0;
            if (VECS[v].lng)
                chk((sum - (int'(VECS[v].iv) * 32768 + w) >= -2) &&
                    (sum - (int'(VECS[v].iv) * 32768 + w) <= 2),
                    "R6 mean", sum, int'(VECS[v].iv) * 32768 + w);
        end

        // R2: with no step the outputs hold while the inputs change
        do_reset();
        int_i = 8'd150; nfr_i = 12'd777; cor_i = 11'h010; psel_i = 1'b0;
        step_i = 1'b1;
        repeat (5) @(negedge clk);
        step_i = 1'b0;
        h_rat = ratio_o; h_b = bcnt_o; h_a = acnt_o; h_e = range_err_o;
        int_i = 8'd40; nfr_i = 12'd5; cor_i = 11'h700; psel_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(ratio_o == h_rat, "R2 ratio", int'(ratio_o), int'(h_rat));
        chk(bcnt_o == h_b, "R2 bcnt", int'(bcnt_o), int'(h_b));
        chk(acnt_o == h_a, "R2 acnt", int'(acnt_o), int'(h_a));
        chk(range_err_o == h_e, "R2 flag", int'(range_err_o), int'(h_e));

        // R7: accumulator state survives an input change
        do_reset();
        int_i = 8'd100; nfr_i = 12'd2048; cor_i = '0; psel_i = 1'b0;
        step_i = 1'b1;
        @(negedge clk);
        chk(ratio_val() == 100, "R7 step1", ratio_val(), 100);
        nfr_i = 12'd0;
        @(negedge clk);
        chk(ratio_val() == 101, "R7 step2", ratio_val(), 101);
        @(negedge clk);
        chk(ratio_val() == 100, "R7 step3", ratio_val(), 100);
        step_i = 1'b0;

        finish_run();
    end
endmodule